// File: doc/BRIEF.md
# Four-state Mealy sequence machine

This block is a clocked synchronous sequential circuit with one serial input bit and one output bit. It moves between four states, named A, B, C and D, on each rising clock edge according to a fixed transition table. The present state is held in two JK-type storage bits. Combinational logic derives the J and K drive of each bit from the present state and the input.

The output is a Mealy output. It depends on the present state and on the input as it is now, and it stays valid for as long as both are held. It follows any input change during a cycle without waiting for a clock edge, so any glitch filtering is left to the consumer.

A synchronous active-low reset returns the machine to A. The 2-bit state code is brought out so that the state sequence can be observed.

Top module: `mealy_seq_machine`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state code is 00 (state A) after that edge, whatever `din` is. Reset overrides the JK drive.
- R2: The state codes are A=00, B=01, C=10 and D=11, with the upper bit on `state_code[1]`. From A, `din`=0 moves to C and `din`=1 moves to B.
- R3: From B, either input value moves to D.
- R4: From C, `din`=0 stays in C and `din`=1 moves to A.
- R5: From D, either input value moves to A.
- R6: `dout` equals `din` in A. `dout` is 0 in B. `dout` equals the inverse of `din` in C and in D.
- R7: Each state bit follows the JK rule at every edge without reset: J=1 with K=0 sets it, J=0 with K=1 clears it, J=K=1 toggles it, and J=K=0 holds it.
- R8: Starting in A, the input sequence 0,0,1,1,0,1,1,1,0,1 produces the states A C C A B D A B D A B and the outputs 0,1,0,1,0,0,1,0,1,1.
- R9: A change of `din` between clock edges changes `dout` within the same cycle, and `state_code` stays unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial input bit |
| dout | output | 1 | Mealy output bit |
| state_code | output | 2 | Present state code |

## Verification
The bench drives a fixed ten-bit input sequence. This sequence passes through every state, and a wrong transition or output shows up as a mismatch at a known position. A sweep then starts from each of the four states in turn and applies each input value once. This separates the eight table entries, including the B and D rows where both inputs lead to the same next state.

Input toggles between clock edges show whether the output tracks the input combinationally rather than through a register. Reset is applied in B with an input that would otherwise lead to D, which shows that reset takes priority over the JK drive.

// File: rtl/mealy_seq_pkg.sv
// Shared widths, state codes and the JK drive bundle for the Mealy machine.
// Assumes a two-bit binary state code; the table logic relies on these values.
package mealy_seq_pkg;

    localparam int STATE_W = 2;
    localparam int HI_BIT  = 1;
    localparam int LO_BIT  = 0;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 2'b00,
        ST_B = 2'b01,
        ST_C = 2'b10,
        ST_D = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic [STATE_W-1:0] j;
        logic [STATE_W-1:0] k;
    } jk_drive_t;

endpackage

// File: rtl/mealy_jk_reg.sv
// A bank of JK-type storage bits with a synchronous active-low reset.
// Assumes J/K are settled before the rising edge; reset wins over J/K.
module mealy_jk_reg #(
    parameter int               W       = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] j,
    input  logic [W-1:0] k,
    output logic [W-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Purpose: update one bit by the JK characteristic, or reset it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[gi] <= RST_VAL[gi];
                end else begin
                    q[gi] <= (j[gi] & ~q[gi]) | (~k[gi] & q[gi]);
                end
            end

            // R1: reset forces the bit to its reset value
            assert_reset_value_R1: assert property (@(posedge clk)
                !rst_n |=> q[gi] == RST_VAL[gi]);

            // R7: JK behaviour for each drive combination
            assert_jk_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (j[gi] && !k[gi]) |=> q[gi]);
            assert_jk_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!j[gi] && k[gi]) |=> !q[gi]);
            assert_jk_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (j[gi] && k[gi]) |=> q[gi] != $past(q[gi]));
            assert_jk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!j[gi] && !k[gi]) |=> $stable(q[gi]));
        end
    endgenerate

endmodule

// File: rtl/mealy_excitation.sv
// Combinational J/K drive for the two state bits from present state and input.
// Assumes the encoding in mealy_seq_pkg; equations derived from the table.
module mealy_excitation
    import mealy_seq_pkg::*;
(
    input  logic [STATE_W-1:0] state,
    input  logic               din,
    output jk_drive_t          drive
);

    logic hi;
    logic lo;

    assign hi = state[HI_BIT];
    assign lo = state[LO_BIT];

    // Purpose: compute set/clear drive so the JK rule yields the next state.
    always_comb begin
        drive = '0;
        // upper bit: set from A on 0 and from B always; clear from C on 1 and from D always
        drive.j[HI_BIT] = lo | ~din;
        drive.k[HI_BIT] = lo | din;
        // lower bit: set only from A on 1; clear from D, hold in B
        drive.j[LO_BIT] = ~hi & din;
        drive.k[LO_BIT] = hi;
    end

endmodule

// File: rtl/mealy_output.sv
// Mealy output decode: a pure function of present state and current input.
// Assumes no register on the path, so input changes pass within the cycle.
module mealy_output
    import mealy_seq_pkg::*;
(
    input  logic [STATE_W-1:0] state,
    input  logic               din,
    output logic               dout
);

    // Purpose: select the output bit for the present state and input.
    always_comb begin
        unique case (state)
            ST_A:    dout = din;
            ST_B:    dout = 1'b0;
            ST_C:    dout = ~din;
            ST_D:    dout = ~din;
            default: dout = 1'b0;
        endcase
    end

endmodule

// File: rtl/mealy_seq_machine.sv
// Four-state Mealy machine: JK state bits, JK drive logic and output decode.
// Assumes one rising-edge clock and a synchronous active-low reset to A.
module mealy_seq_machine
    import mealy_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din,
    output logic               dout,
    output logic [STATE_W-1:0] state_code
);

    jk_drive_t          drive;
    logic [STATE_W-1:0] state_q;

    mealy_excitation u_exc (
        .state (state_q),
        .din   (din),
        .drive (drive)
    );

    mealy_jk_reg #(
        .W       (STATE_W),
        .RST_VAL (ST_A)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .j     (drive.j),
        .k     (drive.k),
        .q     (state_q)
    );

    mealy_output u_out (
        .state (state_q),
        .din   (din),
        .dout  (dout)
    );

    assign state_code = state_q;

    // R2: transitions out of A
    assert_a_on0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_A && !din) |=> state_q == ST_C);
    assert_a_on1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_A && din) |=> state_q == ST_B);
    // R3: B always goes to D
    assert_b_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_B) |=> state_q == ST_D);
    // R4: transitions out of C
    assert_c_on0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_C && !din) |=> state_q == ST_C);
    assert_c_on1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_C && din) |=> state_q == ST_A);
    // R5: D always returns to A
    assert_d_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_D) |=> state_q == ST_A);
    // R6: output relation per state
    assert_out_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_A) |-> dout == din);
    assert_out_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_B) |-> !dout);
    assert_out_cd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_code[HI_BIT] |-> dout == !din);

endmodule

// File: tb/sim_mealy_seq_machine.sv
// Directed bench for the four-state Mealy machine; one task per scenario.
module sim_mealy_seq_machine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       dout;
    logic [1:0] state_code;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] model_st = 2'b00;

    mealy_seq_machine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .dout       (dout),
        .state_code (state_code)
    );

    // 50 MHz: 20 ns period
    always #10 clk = ~clk;

    // Expected next state from the requirement table (A=00 B=01 C=10 D=11).
    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic x);
        case (s)
            2'b00:   return x ? 2'b01 : 2'b10;
            2'b01:   return 2'b11;
            2'b10:   return x ? 2'b00 : 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // Expected output from the requirement table.
    function automatic logic exp_out(input logic [1:0] s, input logic x);
        case (s)
            2'b00:   return x;
            2'b01:   return 1'b0;
            default: return ~x;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: apply x, check output before the edge and state after it.
    task automatic step(input logic x, input string tag);
        din = x;
        #8;
        chk(dout == exp_out(model_st, x), {tag, " dout"}, dout, exp_out(model_st, x));
        chk(state_code == model_st, {tag, " state"}, state_code, model_st);
        @(posedge clk);
        model_st = exp_next(model_st, x);
        #2;
        chk(state_code == model_st, {tag, " next state"}, state_code, model_st);
        @(negedge clk);
    endtask

    // Called at a negedge: synchronous reset for one edge.
    task automatic do_reset(input logic x);
        rst_n = 1'b0;
        din = x;
        @(posedge clk);
        model_st = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b1);
        chk(state_code == 2'b00, "R1 reset state", state_code, 0);
    endtask

    task automatic t_reference_seq();
        logic [9:0] seq   = 10'b0011011101;
        logic [9:0] outs  = 10'b0101001011;
        logic [1:0] sts [11] = '{2'b00, 2'b10, 2'b10, 2'b00, 2'b01, 2'b11,
                                 2'b00, 2'b01, 2'b11, 2'b00, 2'b01};
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) begin
            din = seq[9-i];
            #8;
            chk(dout == outs[9-i], "R8 output", dout, outs[9-i]);
            chk(state_code == sts[i], "R8 state", state_code, sts[i]);
            @(posedge clk);
            @(negedge clk);
        end
        chk(state_code == sts[10], "R8 final state", state_code, sts[10]);
    endtask

    // Reach state s from A, then apply x once.
    task automatic t_table_entry(input logic [1:0] s, input logic x);
        string tag;
        case (s)
            2'b00:   tag = "R2";
            2'b01:   tag = "R3";
            2'b10:   tag = "R4";
            default: tag = "R5";
        endcase
        do_reset(1'b0);
        if (s == 2'b01) step(1'b1, "R2 path");
        if (s == 2'b10) step(1'b0, "R2 path");
        if (s == 2'b11) begin
            step(1'b1, "R2 path");
            step(1'b0, "R3 path");
        end
        step(x, {tag, "/R6 entry"});
    endtask

    task automatic t_table_sweep();
        for (int s = 0; s < 4; s++) begin
            for (int x = 0; x < 2; x++) begin
                t_table_entry(s[1:0], x[0]);
            end
        end
    endtask

    task automatic t_mid_cycle();
        do_reset(1'b0);
        din = 1'b0;
        #2;
        chk(dout == 1'b0, "R9 A din0", dout, 0);
        din = 1'b1;
        #2;
        chk(dout == 1'b1, "R9 A din1", dout, 1);
        chk(state_code == 2'b00, "R9 state held", state_code, 0);
        din = 1'b0;
        #2;
        chk(dout == 1'b0, "R9 A din0 again", dout, 0);
        @(posedge clk);
        @(negedge clk);
        chk(state_code == 2'b10, "R9 uses final din", state_code, 2);
        din = 1'b1;
        #2;
        chk(dout == 1'b0, "R9 C din1", dout, 0);
        din = 1'b0;
        #2;
        chk(dout == 1'b1, "R9 C din0", dout, 1);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_priority();
        do_reset(1'b0);
        step(1'b1, "R1 path");
        chk(state_code == 2'b01, "R1 in B", state_code, 1);
        do_reset(1'b0);
        chk(state_code == 2'b00, "R1 reset over JK", state_code, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_reference_seq();
        t_table_sweep();
        t_mid_cycle();
        t_reset_priority();
        finish_run();
    end

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule